// File: doc/BRIEF.md
# Hashed Frame-Table Translator

This block translates a virtual page number into a physical frame through a table that holds one entry per physical frame instead of one per virtual page. The virtual page number is folded by a hash into an index into that table. The indexed entry carries the virtual page tag it currently serves, the frame number and a resident flag. Every lookup therefore compares tags. The result is one of three outcomes:

- a translation: the frame number followed by the page offset, which is passed through unchanged;
- a page fault: the tag matches but the page is not resident;
- a table miss: the entry belongs to some other page, or has never been loaded, and the full page table must be walked.

Loader logic fills entries through a separate write port, addressing them by index. Chaining of colliding pages and any traffic to backing storage are handled elsewhere.

The design is a fixed two-stage pipeline. It takes one request per cycle with no back-pressure. In stage one the synchronous table is read. In stage two the result is classified and registered. The classification is an enumerated outcome with three values: HIT, FAULT and MISS. The outcome is chosen by this rule:

- MISS when the entry was never loaded or the tag differs;
- otherwise FAULT when the resident flag is clear;
- otherwise HIT.

In the output process the outcome moves the response register from idle (no valid result) to one of the three result kinds. It falls back to idle in any cycle with no request two cycles earlier.

Top module: `ipt_lookup`

## Requirements
- R1: The table index is the XOR of the upper half and the lower half of the virtual page number, cut down to the index width (6 bits by default). Two page numbers with the same fold share one entry.
- R2: `rsp_valid` is high exactly two clock cycles after each cycle in which `req_valid` is high, once per request. Requests may arrive in consecutive cycles.
- R3: When the entry is loaded, its tag equals the requested page number and its resident flag is 1, `rsp_kind` is 0 (HIT). `rsp_paddr` is then the stored frame number in the upper bits followed by the request's page offset in the low `OFF_W` bits.
- R4: When the entry is loaded and its tag matches but its resident flag is 0, `rsp_kind` is 1 (FAULT) and `rsp_paddr` is 0.
- R5: When the entry's tag differs from the requested page number, `rsp_kind` is 2 (MISS) and `rsp_paddr` is 0. The value 3 is never produced.
- R6: An index not written since reset reports MISS, whatever the request.
- R7: A write and a lookup to the same index in the same cycle: the lookup sees the entry as it was before the write. A lookup in the next cycle sees the new contents.
- R8: During and after reset `rsp_valid`, `rsp_kind` and `rsp_paddr` are 0. In any cycle where `rsp_valid` is 0, `rsp_kind` and `rsp_paddr` are also 0.
- R9: A write replaces tag, frame and resident flag together. The page previously served by that entry then reports MISS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_off | input | OFF_W | Page offset carried to the result |
| wr_en | input | 1 | Entry load strobe |
| wr_idx | input | FRAME_W | Table index to load |
| wr_vpn | input | VPN_W | Tag to store |
| wr_frame | input | FRAME_W | Frame number to store |
| wr_present | input | 1 | Resident flag to store |
| rsp_valid | output | 1 | Result strobe, two cycles after the request |
| rsp_kind | output | 2 | 0 HIT, 1 FAULT, 2 MISS |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address on HIT, else 0 |

## Verification
The checker tests, on every cycle, the properties that need no knowledge of the table contents:
- the two-cycle pairing of requests and results;
- the offset carried through on a HIT;
- the zero address on FAULT and MISS;
- the legal outcome codes;
- the quiet outputs while no result is valid.

Only the bench scenarios can show that the hash folds to the right entry, or that colliding tags miss. The same holds for the outcome on never-loaded entries, the old-data behaviour of a same-cycle write and lookup, and the effect of overwriting an entry. The bench shows these by comparing each result against its own model of the table.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [1:0] {
        OUT_HIT   = 2'd0,
        OUT_FAULT = 2'd1,
        OUT_MISS  = 2'd2
    } ipt_outcome_e;

endpackage

// File: rtl/ipt_table_ram.sv
module ipt_table_ram #(
    parameter int AW = 6,
    parameter int DW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd,
    output logic          rd_loaded
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] loaded_q;

    // Storage and read port: nonblocking update gives old data on a
    // same-cycle read and write of one index.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        if (re) begin
            rd <= mem[ra];
        end
    end

    // Per-entry loaded flags, cleared by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q  <= '0;
            rd_loaded <= 1'b0;
        end else begin
            if (re) begin
                rd_loaded <= loaded_q[ra];
            end
            if (we) begin
                loaded_q[wa] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipt_classify.sv
module ipt_classify
    import ipt_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 6
) (
    input  logic [VPN_W-1:0]         vpn,
    input  logic [OFF_W-1:0]         off,
    input  logic [VPN_W-1:0]         ent_tag,
    input  logic [FRAME_W-1:0]       ent_frame,
    input  logic                     ent_present,
    input  logic                     ent_loaded,
    output ipt_outcome_e             outcome,
    output logic [FRAME_W+OFF_W-1:0] paddr
);

    always_comb begin
        if (!ent_loaded || (ent_tag != vpn)) begin
            outcome = OUT_MISS;
        end else if (!ent_present) begin
            outcome = OUT_FAULT;
        end else begin
            outcome = OUT_HIT;
        end
    end

    always_comb begin
        paddr = '0;
        if (outcome == OUT_HIT) begin
            paddr = {ent_frame, off};
        end
    end

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
    import ipt_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [OFF_W-1:0]         req_off,
    input  logic                     wr_en,
    input  logic [FRAME_W-1:0]       wr_idx,
    input  logic [VPN_W-1:0]         wr_vpn,
    input  logic [FRAME_W-1:0]       wr_frame,
    input  logic                     wr_present,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_kind,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr
);
    localparam int IDX_W = FRAME_W;
    localparam int HALF  = VPN_W / 2;
    localparam int UP_LO = VPN_W - HALF;
    localparam int ENT_W = VPN_W + FRAME_W + 1;
    localparam int PA_W  = FRAME_W + OFF_W;

    // Fold: upper half XOR lower half, kept to the index width.
    logic [IDX_W-1:0] lk_idx;
    always_comb begin
        lk_idx = req_vpn[UP_LO +: IDX_W] ^ req_vpn[0 +: IDX_W];
    end

    logic [ENT_W-1:0] wr_word;
    logic [ENT_W-1:0] rd_word;
    logic             rd_loaded;

    assign wr_word = {wr_vpn, wr_frame, wr_present};

    ipt_table_ram #(
        .AW (IDX_W),
        .DW (ENT_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .wa        (wr_idx),
        .wd        (wr_word),
        .re        (req_valid),
        .ra        (lk_idx),
        .rd        (rd_word),
        .rd_loaded (rd_loaded)
    );

    // Stage one: request held beside the table read.
    logic             s1_valid;
    logic [VPN_W-1:0] s1_vpn;
    logic [OFF_W-1:0] s1_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_vpn   <= '0;
            s1_off   <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_vpn <= req_vpn;
                s1_off <= req_off;
            end
        end
    end

    ipt_outcome_e    outcome;
    logic [PA_W-1:0] cls_paddr;

    ipt_classify #(
        .VPN_W   (VPN_W),
        .OFF_W   (OFF_W),
        .FRAME_W (FRAME_W)
    ) classify_i (
        .vpn         (s1_vpn),
        .off         (s1_off),
        .ent_tag     (rd_word[ENT_W-1 -: VPN_W]),
        .ent_frame   (rd_word[FRAME_W:1]),
        .ent_present (rd_word[0]),
        .ent_loaded  (rd_loaded),
        .outcome     (outcome),
        .paddr       (cls_paddr)
    );

    // Stage two: response register driven by the classified outcome.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= 2'd0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                unique case (outcome)
                    OUT_HIT: begin
                        rsp_kind  <= OUT_HIT;
                        rsp_paddr <= cls_paddr;
                    end
                    OUT_FAULT: begin
                        rsp_kind  <= OUT_FAULT;
                        rsp_paddr <= '0;
                    end
                    OUT_MISS: begin
                        rsp_kind  <= OUT_MISS;
                        rsp_paddr <= '0;
                    end
                    default: begin
                        rsp_kind  <= OUT_MISS;
                        rsp_paddr <= '0;
                    end
                endcase
            end else begin
                rsp_kind  <= 2'd0;
                rsp_paddr <= '0;
            end
        end
    end

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [OFF_W-1:0]         req_off,
    input logic                     rsp_valid,
    input logic [1:0]               rsp_kind,
    input logic [FRAME_W+OFF_W-1:0] rsp_paddr
);
    logic [1:0]       pend_v;
    logic [OFF_W-1:0] off_d1;
    logic [OFF_W-1:0] off_d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v <= 2'b00;
            off_d1 <= '0;
            off_d2 <= '0;
        end else begin
            pend_v <= {pend_v[0], req_valid};
            off_d1 <= req_off;
            off_d2 <= off_d1;
        end
    end

    a_r2_result_follows_request: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_valid == pend_v[1]);

    a_r3_hit_keeps_offset: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_d2);

    a_r4_nonhit_zero_address: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 2'd0) |-> rsp_paddr == '0);

    a_r5_kind_legal: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_kind != 2'd3);

    a_r8_idle_outputs_zero: assert property (
        @(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_kind == 2'd0 && rsp_paddr == '0));

endmodule

bind ipt_lookup ipt_lookup_chk #(
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_off   (req_off),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_paddr (rsp_paddr)
);

// File: tb/ipt_lookup_tb.sv
`timescale 1ns/1ps
module ipt_lookup_tb_top;
    localparam int VPN_W = 20;
    localparam int OFF_W = 12;
    localparam int FW    = 6;
    localparam int PA_W  = FW + OFF_W;
    localparam int DEPTH = 1 << FW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic             wr_en = 1'b0;
    logic [FW-1:0]    wr_idx = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [FW-1:0]    wr_frame = '0;
    logic             wr_present = 1'b0;
    logic             rsp_valid;
    logic [1:0]       rsp_kind;
    logic [PA_W-1:0]  rsp_paddr;

    always #2.5 clk = ~clk;

    ipt_lookup #(.VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_off(req_off), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_frame(wr_frame), .wr_present(wr_present), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr)
    );

    typedef struct {
        logic [1:0]      kind;
        logic [PA_W-1:0] paddr;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;

    // Independent model of the table.
    logic [VPN_W-1:0] m_tag    [DEPTH];
    logic [FW-1:0]    m_frame  [DEPTH];
    logic             m_pres   [DEPTH];
    logic             m_loaded [DEPTH];

    function automatic logic [FW-1:0] fold(input logic [VPN_W-1:0] v);
        logic [9:0] x;
        x = v[19:10] ^ v[9:0];
        return x[FW-1:0];
    endfunction

    function automatic exp_t predict(input logic [VPN_W-1:0] v,
                                     input logic [OFF_W-1:0] o, input string t);
        exp_t e;
        logic [FW-1:0] i;
        i = fold(v);
        e.tag = t;
        if (!m_loaded[i] || m_tag[i] != v) begin
            e.kind = 2'd2; e.paddr = '0;
        end else if (!m_pres[i]) begin
            e.kind = 2'd1; e.paddr = '0;
        end else begin
            e.kind = 2'd0; e.paddr = {m_frame[i], o};
        end
        return e;
    endfunction

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic model_write(input logic [FW-1:0] i, input logic [VPN_W-1:0] v,
                               input logic [FW-1:0] f, input logic p);
        m_tag[i] = v; m_frame[i] = f; m_pres[i] = p; m_loaded[i] = 1'b1;
    endtask

    task automatic load(input logic [FW-1:0] i, input logic [VPN_W-1:0] v,
                        input logic [FW-1:0] f, input logic p);
        model_write(i, v, f, p);
        wr_en = 1'b1; wr_idx = i; wr_vpn = v; wr_frame = f; wr_present = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o,
                          input string t);
        q.push_back(predict(v, o, t));
        req_valid = 1'b1; req_vpn = v; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Lookup and load in one cycle: expectation taken before the write.
    task automatic lookup_load(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o,
                               input string t, input logic [FW-1:0] i,
                               input logic [VPN_W-1:0] wv, input logic [FW-1:0] f,
                               input logic p);
        q.push_back(predict(v, o, t));
        model_write(i, wv, f, p);
        req_valid = 1'b1; req_vpn = v; req_off = o;
        wr_en = 1'b1; wr_idx = i; wr_vpn = wv; wr_frame = f; wr_present = p;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: pops one expected item per result.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check("R2 unexpected result", 32'(rsp_valid), 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " kind"}, 32'(rsp_kind), 32'(e.kind));
                check({e.tag, " paddr"}, 32'(rsp_paddr), 32'(e.paddr));
            end
        end
    end

    logic done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_loaded[i] = 1'b0; m_tag[i] = '0; m_frame[i] = '0; m_pres[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R8 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R8 reset rsp_kind", 32'(rsp_kind), 32'd0);
        check("R8 reset rsp_paddr", 32'(rsp_paddr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: nothing loaded yet
        lookup(20'h12345, 12'h0AB, "R6 unloaded");
        // R3: hit with offset carried
        load(fold(20'h00001), 20'h00001, 6'd5, 1'b1);
        lookup(20'h00001, 12'h123, "R3 hit");
        // R1/R5: same fold, different tag
        lookup(20'h00400, 12'h001, "R1 R5 collision miss");
        // R4: resident flag clear
        load(fold(20'h12345), 20'h12345, 6'd9, 1'b0);
        lookup(20'h12345, 12'hFFF, "R4 fault");
        // R2: back-to-back requests
        lookup(20'h00001, 12'hABC, "R2 burst hit");
        lookup(20'h12345, 12'h000, "R2 burst fault");
        lookup(20'h00400, 12'h555, "R2 burst miss");
        repeat (3) @(negedge clk);
        check("R2 results drained", 32'(q.size()), 32'd0);
        // R7: same-cycle write sees old entry; R9: overwrite
        lookup_load(20'h00001, 12'h777, "R7 old data", fold(20'h00001),
                    20'h00400, 6'd33, 1'b1);
        lookup(20'h00001, 12'h010, "R9 replaced tag misses");
        lookup(20'h00400, 12'h020, "R7 R9 new data visible");
        // R1: fold sweep across upper halves
        for (int k = 0; k < 8; k++) begin
            logic [VPN_W-1:0] v;
            v = {10'(k * 97 + 3), 10'(k * 41 + 17)};
            load(fold(v), v, 6'(k + 40), 1'b1);
            lookup(v, 12'(k * 300), "R1 fold hit");
            lookup(v ^ 20'h00401, 12'(k), "R1 R5 same fold miss");
        end
        repeat (4) @(negedge clk);
        check("R2 all results seen", 32'(q.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule